// File: doc/BRIEF.md
# Biphase-Mark Line Bit Decoder

This block turns an already deglitched biphase-mark-coded serial line into a stream of decoded bits. Every bit cell begins with a level change on the line. A 1 cell has a second change near its middle. A 0 cell has none. The decoder counts sampling-clock cycles from each cell boundary and compares the count with a decision threshold supplied at runtime. That threshold is nominally three quarters of one unit interval (UI), and separate training logic keeps it current. A change seen before the count reaches the threshold decides a 1. A count that reaches the threshold with no change decides a 0. Once a bit is decided, the decoder stops looking at the rest of that cell. The next line change is taken as the following cell boundary.

The sampling clock should run at roughly 60 times the line bit rate. Decoded bits leave as a valid-only stream: `bit_o` qualified by a one-cycle `bit_valid_o` strobe, both registered. The serial line cannot be paused, so the stream has no ready input and cannot be back-pressured. The consumer must take every strobe in the cycle it appears. If the line goes quiet for longer than twice the threshold (about 1.5 UI) after a boundary, the decoder raises `idle_o` and hunts for a fresh boundary. Deasserting `en` holds the decoder in that hunting state, with no output.

Top module: `bmc_bit_decoder`

## Requirements
- R1: While reset is held, `bit_valid_o`, `bit_o` and `idle_o` are all 0.
- R2: A line change arriving while the count since the cell boundary is below `thresh_i` decodes as a 1. The strobe appears two clock cycles after the mid-cell line change.
- R3: A cell with no line change before the count reaches `thresh_i` decodes as a 0. The strobe appears `thresh_i` + 2 clock cycles after the boundary line change.
- R4: `thresh_i` is read every cycle, so a new value governs the bits decoded after it is applied. With a 40-cycle UI and a threshold of 30, bits decode correctly.
- R5: After each decision, the next line change, rising or falling, is the next cell boundary. Mixed bit patterns with ±10% UI jitter on every cell half decode in transmit order.
- R6: `bit_valid_o` is a single-cycle strobe and is never high in two consecutive cycles.
- R7: If no line change occurs within 2×`thresh_i` cycles of a boundary, `idle_o` goes to 1 and no strobe is issued. `idle_o` stays at 1 until the next line change, which clears it and starts a new cell.
- R8: While `en` is 0, no strobe is produced, whatever the line does. After `en` returns to 1, the first line change is a cell boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, about 60x the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Decoding enable from training logic |
| line_i | input | 1 | Deglitched line level |
| thresh_i | input | CNT_W | Decision threshold in sample cycles (about 0.75 UI) |
| bit_o | output | 1 | Decoded bit, valid when bit_valid_o is 1 |
| bit_valid_o | output | 1 | One-cycle strobe per decoded bit |
| idle_o | output | 1 | Line silent past the timeout; hunting for a boundary |

## Verification
The hardest thing to observe from the ports is the exact moment of each decision. A 1 is decided as soon as its mid-cell change arrives, while a 0 is decided only when the threshold expires. Both events are buried inside a stream whose cell lengths jitter. The driver therefore times selected cells itself: it counts sampling cycles from the line change it made until the strobe appears, and checks the two-cycle and threshold-plus-two latencies. Jittered streams at two UI lengths, a silent gap to reach the timeout, and line activity while disabled cover the remaining paths.

// File: rtl/bmcd_pkg.sv
package bmcd_pkg;
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_SEEK   = 2'd2
  } dec_state_e;
endpackage

// File: rtl/bmcd_edge_det.sv
// Delays the line through a short register chain; a difference between the
// two oldest taps marks a transition of either polarity.
module bmcd_edge_det #(
  parameter int DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic edge_o
);
  logic [DLY-1:0] tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap <= '0;
    else        tap <= {tap[DLY-2:0], line_i};
  end

  assign edge_o = tap[DLY-1] ^ tap[DLY-2];
endmodule

// File: rtl/bmcd_span_ctr.sv
// Counts sample cycles since the last cell boundary, saturating at all-ones.
module bmcd_span_ctr #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_o <= '0;
    else if (restart_i)    cnt_o <= {{(W-1){1'b0}}, 1'b1};
    else if (cnt_o != '1)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/bmcd_bit_fsm.sv
module bmcd_bit_fsm
  import bmcd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic [CNT_W:0]   cnt_i,
  output logic             restart_o,
  output logic             bit_o,
  output logic             valid_o,
  output logic             idle_o
);
  localparam int SPAN_W = CNT_W + 1;

  dec_state_e st_q, st_d;
  logic [SPAN_W-1:0] thr_ext, limit;
  logic decide, dval, set_idle, clr_idle;

  assign thr_ext = {1'b0, thresh_i};
  assign limit   = {thresh_i, 1'b0};  // twice 0.75 UI, about 1.5 UI

  always_comb begin
    st_d      = st_q;
    restart_o = 1'b0;
    decide    = 1'b0;
    dval      = 1'b0;
    set_idle  = 1'b0;
    clr_idle  = 1'b0;
    if (!en_i) begin
      st_d     = ST_HUNT;
      clr_idle = 1'b1;
    end else begin
      unique case (st_q)
        ST_HUNT: begin
          if (edge_i) begin
            restart_o = 1'b1;
            clr_idle  = 1'b1;
            st_d      = ST_WINDOW;
          end
        end
        ST_WINDOW: begin
          if (edge_i) begin
            decide = 1'b1;
            if (cnt_i < thr_ext) begin
              dval = 1'b1;          // mid-cell change: a one
              st_d = ST_SEEK;
            end else begin
              restart_o = 1'b1;     // change exactly at expiry: zero, new cell
            end
          end else if (cnt_i >= thr_ext) begin
            decide = 1'b1;          // window closed quietly: a zero
            st_d   = ST_SEEK;
          end
        end
        ST_SEEK: begin
          if (edge_i) begin
            restart_o = 1'b1;
            st_d      = ST_WINDOW;
          end else if (cnt_i >= limit) begin
            set_idle = 1'b1;
            st_d     = ST_HUNT;
          end
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_HUNT;
      bit_o   <= 1'b0;
      valid_o <= 1'b0;
      idle_o  <= 1'b0;
    end else begin
      st_q    <= st_d;
      valid_o <= decide;
      if (decide) bit_o <= dval;
      if (set_idle)      idle_o <= 1'b1;
      else if (clr_idle) idle_o <= 1'b0;
    end
  end

  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_one_needs_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && bit_o) |-> $past(edge_i));

  assert_zero_at_threshold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !bit_o) |-> $past(cnt_i >= thr_ext));

  assert_quiet_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !valid_o);

  assert_idle_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> !valid_o);
endmodule

// File: rtl/bmc_bit_decoder.sv
module bmc_bit_decoder #(
  parameter int CNT_W    = 8,
  parameter int EDGE_DLY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             line_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             bit_o,
  output logic             bit_valid_o,
  output logic             idle_o
);
  localparam int SPAN_W = CNT_W + 1;

  logic              edge_w;
  logic              restart_w;
  logic [SPAN_W-1:0] cnt_w;

  bmcd_edge_det #(.DLY(EDGE_DLY)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .line_i(line_i),
    .edge_o(edge_w)
  );

  bmcd_span_ctr #(.W(SPAN_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart_i(restart_w),
    .cnt_o    (cnt_w)
  );

  bmcd_bit_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en),
    .edge_i   (edge_w),
    .thresh_i (thresh_i),
    .cnt_i    (cnt_w),
    .restart_o(restart_w),
    .bit_o    (bit_o),
    .valid_o  (bit_valid_o),
    .idle_o   (idle_o)
  );

  assert_ctr_restarts_on_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_w |=> (cnt_w == {{(SPAN_W-1){1'b0}}, 1'b1}));
endmodule

// File: tb/bmc_bit_decoder_tb.sv
module bmc_bit_decoder_tb;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic             line = 1'b0;
  logic [CNT_W-1:0] thresh = 8'd45;
  logic             bit_o, bit_valid_o, idle_o;

  int n_chk = 0, n_fail = 0, n_strobe = 0;
  bit done = 1'b0;
  bit exp_q[$];
  string cur_tag = "R5";

  always #5 clk = ~clk;

  bmc_bit_decoder #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .line_i(line), .thresh_i(thresh),
    .bit_o(bit_o), .bit_valid_o(bit_valid_o), .idle_o(idle_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int jit(input int span);
    return int'($urandom_range(2 * span, 0)) - span;
  endfunction

  // scoreboard monitor
  initial begin
    bit prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev && bit_valid_o) chk(1'b0, "R6", "back-to-back strobe", 1, 0);
        if (bit_valid_o) begin
          n_strobe++;
          if (exp_q.size() == 0) chk(1'b0, cur_tag, "unexpected strobe", 1, 0);
          else begin
            bit e;
            e = exp_q.pop_front();
            chk(bit_o == e, cur_tag, "decoded bit", int'(bit_o), int'(e));
          end
        end
        prev = bit_valid_o;
      end
    end
  end

  task automatic wait_n(input int n, input bit meas, inout int lat);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (meas && lat < 0 && bit_valid_o) lat = i;
    end
  endtask

  // drive one cell starting at a negedge; optionally time the strobe
  task automatic drive_bit(input bit b, input int ui, input bit meas);
    int h, lat;
    lat = -1;
    line = ~line;
    exp_q.push_back(b);
    if (b) begin
      h = ui / 2 + jit(ui / 20);
      wait_n(h, 1'b0, lat);
      line = ~line;
      wait_n(ui - h, meas, lat);
      if (meas) chk(lat == 2, "R2", "one latency", lat, 2);
    end else begin
      h = ui + jit(ui / 10);
      wait_n(h, meas, lat);
      if (meas) chk(lat == int'(thresh) + 2, "R3", "zero latency", lat, int'(thresh) + 2);
    end
  endtask

  task automatic idle_gap(input int n);
    int d;
    d = -1;
    wait_n(n, 1'b0, d);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(bit_valid_o == 1'b0, "R1", "valid in reset", int'(bit_valid_o), 0);
    chk(bit_o == 1'b0, "R1", "bit in reset", int'(bit_o), 0);
    chk(idle_o == 1'b0, "R1", "idle in reset", int'(idle_o), 0);
    rst_n = 1'b1;
    en = 1'b1;
    idle_gap(3);

    // timed cells: R3 zero latency, R2 one latency
    cur_tag = "R3";
    drive_bit(1'b0, 60, 1'b1);
    cur_tag = "R2";
    drive_bit(1'b1, 60, 1'b1);
    drive_bit(1'b0, 60, 1'b1);
    drive_bit(1'b1, 60, 1'b1);

    // R5 jittered streams
    cur_tag = "R5";
    for (int i = 0; i < 32; i++) drive_bit(i[0], 60, 1'b0);
    for (int i = 0; i < 12; i++) drive_bit(1'b0, 60, 1'b0);
    for (int i = 0; i < 12; i++) drive_bit(1'b1, 60, 1'b0);
    for (int i = 0; i < 40; i++) drive_bit(1'($urandom_range(1, 0)), 60, 1'b0);

    // R7 silence leads to idle
    idle_gap(150);
    chk(exp_q.size() == 0, "R5", "bits left undecoded", exp_q.size(), 0);
    chk(idle_o == 1'b1, "R7", "idle after silence", int'(idle_o), 1);

    // R4 new threshold with a shorter UI; first change clears idle (R7)
    thresh = 8'd30;
    cur_tag = "R4";
    drive_bit(1'b0, 40, 1'b1);
    chk(idle_o == 1'b0, "R7", "idle cleared by change", int'(idle_o), 0);
    for (int i = 0; i < 24; i++) drive_bit(1'($urandom_range(1, 0)), 40, 1'b0);
    drive_bit(1'b1, 40, 1'b1);
    idle_gap(100);
    chk(exp_q.size() == 0, "R4", "bits left undecoded", exp_q.size(), 0);

    // R8 disabled: line activity produces nothing
    begin
      int s0;
      s0 = n_strobe;
      cur_tag = "R8";
      en = 1'b0;
      for (int i = 0; i < 12; i++) begin
        line = ~line;
        idle_gap(17 + (i % 3) * 9);
      end
      chk(n_strobe == s0, "R8", "strobes while disabled", n_strobe - s0, 0);
      chk(idle_o == 1'b0, "R8", "idle while disabled", int'(idle_o), 0);
      en = 1'b1;
      idle_gap(5);
      for (int i = 0; i < 8; i++) drive_bit(i[1], 40, 1'b0);
      idle_gap(100);
      chk(exp_q.size() == 0, "R8", "bits after re-enable", exp_q.size(), 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule